// File: doc/BRIEF.md
# Sklansky Prefix Adder

This block adds two operands in a single combinational path and returns a result one bit wider than the wider operand. The carries come from a divide-and-conquer parallel-prefix tree of two-input cells. It does not use a ripple chain. The tree has ceil(log2 N) levels. At each level the lower group's signals fan out to twice as many positions as at the level before.

Each bit position first forms a propagate term (a XOR b) and a generate term (a AND b). The carry-in is a constant zero. It occupies the lowest position of the prefix network, just below bit 0. Black cells merge a higher group with a lower group and produce both group generate and group propagate. Grey cells produce only the group generate, and they appear wherever the merged group reaches down to the carry-in. A last XOR stage forms each sum bit from its propagate term and its carry.

The top result bit depends on the mode. An unsigned instance (`SIGNED=0`) puts the carry-out there. A signed instance (`SIGNED=1`) puts the XOR of both operand sign bits with the carry-out there, which gives a correctly sign-extended two's-complement sum. Operands of unequal width are first widened to N = max(WA, WB). The widening uses sign extension in signed mode and zero extension in unsigned mode.

Top module: `sklansky_adder`

## Requirements
- R1: In unsigned mode, `sum` equals the (N+1)-bit value a + b, with both operands read as unsigned numbers.
- R2: In signed mode, `sum` read as an (N+1)-bit two's-complement number equals a + b, with both operands read as two's-complement numbers.
- R3: The carry into bit 0 is zero, so zero plus zero gives an all-zero result in both modes.
- R4: In unsigned mode, an operand narrower than N is zero-extended before the addition.
- R5: In signed mode, an operand narrower than N is sign-extended before the addition. Its top bit WA-1 or WB-1 is repeated up to bit N-1.
- R6: Every carry produced by the prefix tree obeys c[i+1] = g[i] OR (p[i] AND c[i]). Bit N of an unsigned result is c[N].
- R7: Each sum bit i below N equals a_ext[i] XOR b_ext[i] XOR c[i]. These N bits are identical in the two modes for the same extended operands.
- R8: In signed mode, sum[N] equals a_ext[N-1] XOR b_ext[N-1] XOR c[N].
- R9: The corner cases give exact results at the widths under test. These cases are all-ones plus one, all-ones plus all-ones, most-negative plus most-negative, and most-positive plus most-positive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WA | First operand |
| b | input | WB | Second operand |
| sum | output | N+1 | Result; bit N is the carry-out (unsigned) or the sign bit (signed) |

## Verification
Every pair of 8-bit operands is applied to an unsigned instance and a signed instance. This separates a correct carry tree from one with a misrouted partner or a black/grey mix-up, because each such fault breaks only some positions. The same values drive two instances whose second operand is 5 bits wide. Their results differ only through the extension rule, so zero and sign extension are told apart. A 16-bit pair of instances receives random operands, which exercises the deeper tree levels. Fixed all-ones, most-negative and most-positive vectors then push every carry to propagate the full width and hit the sign-bit formula at its extremes.

// File: rtl/skl_pkg.sv
package skl_pkg;

  function automatic logic grp_gen(input logic g_hi, input logic p_hi, input logic g_lo);
    return g_hi | (p_hi & g_lo);
  endfunction

  function automatic logic grp_prop(input logic p_hi, input logic p_lo);
    return p_hi & p_lo;
  endfunction

  function automatic logic sum_bit(input logic p, input logic c);
    return p ^ c;
  endfunction

endpackage

// File: rtl/skl_operand_pg.sv
module skl_operand_pg #(
  parameter int WA     = 8,
  parameter int WB     = 8,
  parameter bit SIGNED = 1'b0,
  localparam int N     = (WA > WB) ? WA : WB
) (
  input  logic [WA-1:0] a,
  input  logic [WB-1:0] b,
  output logic [N-1:0]  a_x,
  output logic [N-1:0]  b_x,
  output logic [N-1:0]  p,
  output logic [N-1:0]  g
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i < WA) begin : g_a_in
      assign a_x[i] = a[i];
    end else if (SIGNED) begin : g_a_sx
      assign a_x[i] = a[WA-1];
    end else begin : g_a_zx
      assign a_x[i] = 1'b0;
    end
    if (i < WB) begin : g_b_in
      assign b_x[i] = b[i];
    end else if (SIGNED) begin : g_b_sx
      assign b_x[i] = b[WB-1];
    end else begin : g_b_zx
      assign b_x[i] = 1'b0;
    end
    assign p[i] = a_x[i] ^ b_x[i];
    assign g[i] = a_x[i] & b_x[i];
  end
endmodule

// File: rtl/skl_prefix_tree.sv
module skl_prefix_tree
  import skl_pkg::*;
#(
  parameter int N = 8,
  localparam int LV = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  output logic [N:0]   carry
);
  // Position 0 holds the constant carry-in; position j>0 holds bit j-1.
  logic [N-1:0] gv [0:LV];
  logic [N-1:0] pv [0:LV];

  assign gv[0] = {g[N-2:0], 1'b0};
  assign pv[0] = {p[N-2:0], 1'b0};

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar j = 0; j < N; j++) begin : g_pos
      if (((j >> l) & 1) == 1) begin : g_merge
        localparam int PART = ((j >> l) << l) - 1;
        if (j < (2 << l)) begin : g_grey
          assign gv[l+1][j] = grp_gen(gv[l][j], pv[l][j], gv[l][PART]);
          assign pv[l+1][j] = 1'b0;
        end else begin : g_black
          assign gv[l+1][j] = grp_gen(gv[l][j], pv[l][j], gv[l][PART]);
          assign pv[l+1][j] = grp_prop(pv[l][j], pv[l][PART]);
        end
      end else begin : g_pass
        assign gv[l+1][j] = gv[l][j];
        assign pv[l+1][j] = pv[l][j];
      end
    end
  end

  assign carry[N-1:0] = gv[LV];
  // Final grey cell: carry-out from the top bit and the carry into it.
  assign carry[N] = grp_gen(g[N-1], p[N-1], gv[LV][N-1]);
endmodule

// File: rtl/skl_sum_stage.sv
module skl_sum_stage
  import skl_pkg::*;
#(
  parameter int N      = 8,
  parameter bit SIGNED = 1'b0
) (
  input  logic [N-1:0] p,
  input  logic [N:0]   carry,
  input  logic         a_msb,
  input  logic         b_msb,
  output logic [N:0]   sum
);
  for (genvar i = 0; i < N; i++) begin : g_sum
    assign sum[i] = sum_bit(p[i], carry[i]);
  end
  if (SIGNED) begin : g_top_signed
    assign sum[N] = a_msb ^ b_msb ^ carry[N];
  end else begin : g_top_unsigned
    assign sum[N] = carry[N];
  end
endmodule

// File: rtl/sklansky_adder.sv
module sklansky_adder #(
  parameter int WA     = 8,
  parameter int WB     = 8,
  parameter bit SIGNED = 1'b0,
  localparam int N     = (WA > WB) ? WA : WB
) (
  input  logic [WA-1:0] a,
  input  logic [WB-1:0] b,
  output logic [N:0]    sum
);
  logic [N-1:0] a_x;
  logic [N-1:0] b_x;
  logic [N-1:0] p;
  logic [N-1:0] g;
  logic [N:0]   carry;

  skl_operand_pg #(.WA(WA), .WB(WB), .SIGNED(SIGNED)) u_pg (
    .a(a), .b(b), .a_x(a_x), .b_x(b_x), .p(p), .g(g)
  );

  skl_prefix_tree #(.N(N)) u_tree (
    .p(p), .g(g), .carry(carry)
  );

  skl_sum_stage #(.N(N), .SIGNED(SIGNED)) u_sum (
    .p(p), .carry(carry), .a_msb(a_x[N-1]), .b_msb(b_x[N-1]), .sum(sum)
  );
endmodule

// File: rtl/sklansky_adder_chk.sv
module sklansky_adder_chk #(
  parameter int WA     = 8,
  parameter int WB     = 8,
  parameter bit SIGNED = 1'b0,
  localparam int N     = (WA > WB) ? WA : WB
) (
  input logic [WA-1:0] a,
  input logic [WB-1:0] b,
  input logic [N-1:0]  a_x,
  input logic [N-1:0]  b_x,
  input logic [N:0]    carry,
  input logic [N:0]    sum
);
  logic ready;
  assign ready = !$isunknown({a, b, a_x, b_x, carry, sum});

  always_comb begin
    if (ready) begin
      // R3
      carry_in_zero_chk: assert (carry[0] == 1'b0);
      if ((a == '0) && (b == '0)) begin
        // R3
        zero_sum_chk: assert (sum == '0);
      end
      for (int i = 0; i < N; i++) begin
        // R6
        carry_ripple_chk: assert (carry[i+1] == ((a_x[i] & b_x[i]) | ((a_x[i] ^ b_x[i]) & carry[i])));
        // R7
        sum_bit_chk: assert (sum[i] == (a_x[i] ^ b_x[i] ^ carry[i]));
        // R4
        if (i >= WA) begin
          a_ext_chk: assert (a_x[i] == (SIGNED ? a[WA-1] : 1'b0));
        end
        // R5
        if (i >= WB) begin
          b_ext_chk: assert (b_x[i] == (SIGNED ? b[WB-1] : 1'b0));
        end
      end
      if (SIGNED) begin
        // R8
        sign_top_chk: assert (sum[N] == (a_x[N-1] ^ b_x[N-1] ^ carry[N]));
      end else begin
        // R6
        carry_out_chk: assert (sum[N] == carry[N]);
      end
    end
  end
endmodule

bind sklansky_adder sklansky_adder_chk #(.WA(WA), .WB(WB), .SIGNED(SIGNED)) u_chk (
  .a(a), .b(b), .a_x(a_x), .b_x(b_x), .carry(carry), .sum(sum)
);

// File: tb/sklansky_adder_tb.sv
module sklansky_adder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [8:0]  r_u, r_s, r_un, r_sn;
  logic [16:0] r_wu, r_ws;

  int total = 0;
  int bad = 0;
  bit done = 0;

  sklansky_adder #(.WA(8), .WB(8), .SIGNED(1'b0)) u_dut (.a(a8), .b(b8), .sum(r_u));
  sklansky_adder #(.WA(8), .WB(8), .SIGNED(1'b1)) u_dut_s (.a(a8), .b(b8), .sum(r_s));
  sklansky_adder #(.WA(8), .WB(5), .SIGNED(1'b0)) u_dut_un (.a(a8), .b(b8[4:0]), .sum(r_un));
  sklansky_adder #(.WA(8), .WB(5), .SIGNED(1'b1)) u_dut_sn (.a(a8), .b(b8[4:0]), .sum(r_sn));
  sklansky_adder #(.WA(16), .WB(16), .SIGNED(1'b0)) u_dut_w (.a(a16), .b(b16), .sum(r_wu));
  sklansky_adder #(.WA(16), .WB(16), .SIGNED(1'b1)) u_dut_ws (.a(a16), .b(b16), .sum(r_ws));

  // Behavioural reference: widen per mode, add as integers, keep n+1 bits.
  function automatic longint widen(longint v, int w, bit sgn);
    longint m = (longint'(1) << w) - 1;
    longint x = v & m;
    if (sgn && x[w-1]) x = x - (longint'(1) << w);
    return x;
  endfunction

  function automatic longint ref_sum(longint av, int wa, longint bv, int wb, bit sgn);
    int n = (wa > wb) ? wa : wb;
    longint s = widen(av, wa, sgn) + widen(bv, wb, sgn);
    return s & ((longint'(1) << (n + 1)) - 1);
  endfunction

  task automatic chk(string req, longint got, longint exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h exp=%0h (a8=%0h b8=%0h a16=%0h b16=%0h)",
               req, got, exp, a8, b8, a16, b16);
    end
  endtask

  task automatic check_all(string tag);
    chk({"R1 ", tag}, longint'(r_u),  ref_sum(a8, 8, b8, 8, 0));
    chk({"R2 ", tag}, longint'(r_s),  ref_sum(a8, 8, b8, 8, 1));
    chk({"R4 ", tag}, longint'(r_un), ref_sum(a8, 8, b8 & 8'h1f, 5, 0));
    chk({"R5 ", tag}, longint'(r_sn), ref_sum(a8, 8, b8 & 8'h1f, 5, 1));
    chk({"R1 wide ", tag}, longint'(r_wu), ref_sum(a16, 16, b16, 16, 0));
    chk({"R2 wide ", tag}, longint'(r_ws), ref_sum(a16, 16, b16, 16, 1));
    // R7: low bits agree between modes
    chk({"R7 ", tag}, longint'(r_s[7:0]), longint'(r_u[7:0]));
    // R8: signed top bit from operand signs and the unsigned carry-out
    chk({"R8 ", tag}, longint'(r_s[8]), longint'(a8[7] ^ b8[7] ^ r_u[8]));
  endtask

  task automatic apply(logic [7:0] x, logic [7:0] y, logic [15:0] xw, logic [15:0] yw, string tag);
    @(posedge clk);
    a8 <= x; b8 <= y; a16 <= xw; b16 <= yw;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3: idle zero operands give zero
    chk("R3 reset u", longint'(r_u), 0);
    chk("R3 reset s", longint'(r_s), 0);
    chk("R3 reset wide", longint'(r_ws), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        apply(8'(i), 8'(j), 16'($urandom), 16'($urandom), "exhaustive");
      end
    end
    // R9 corners
    apply(8'hff, 8'h01, 16'hffff, 16'h0001, "R9 ones+1");
    chk("R9 ones+1", longint'(r_u), 64'h100);
    chk("R9 ones+1 wide", longint'(r_wu), 64'h10000);
    apply(8'hff, 8'hff, 16'hffff, 16'hffff, "R9 ones+ones");
    chk("R9 ones+ones", longint'(r_u), 64'h1fe);
    chk("R9 ones+ones signed", longint'(r_s), 64'h1fe);
    apply(8'h80, 8'h80, 16'h8000, 16'h8000, "R9 minneg");
    chk("R9 minneg signed", longint'(r_s), 64'h100);
    chk("R9 minneg wide", longint'(r_ws), 64'h10000);
    apply(8'h7f, 8'h7f, 16'h7fff, 16'h7fff, "R9 maxpos");
    chk("R9 maxpos signed", longint'(r_s), 64'h0fe);
    chk("R9 maxpos wide", longint'(r_ws), 64'h0fffe);
    apply(8'h80, 8'h10, 16'h8000, 16'h0001, "R5 narrow neg");
    chk("R5 narrow neg", longint'(r_sn), 64'h170);
    chk("R4 narrow zero", longint'(r_un), 64'h090);
    apply(8'h00, 8'h00, 16'h0000, 16'h0000, "R3 zero");
    chk("R3 zero", longint'(r_u), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule